// File: doc/BRIEF.md
# Two-Band Programmable Clock Divider with Decoded Swallow Control

This block divides a fast input clock by an even ratio M = 2·(8·P + S). The input clock first passes through a halving stage. An 8/9 prescaler follows it, and a second prescaler counts the 8/9 output periods, wrapping after P = 32 or P = 34 of them. A separate swallow counter and a separate program counter are not used. Two decoders look at the second prescaler's count instead: one for the channel match and one for the terminal count. The channel match sets a JK flop and the terminal count clears it. That flop is the modulus of the 8/9 prescaler. Within each output cycle, the first S prescaler periods last 9 half-rate ticks and the remaining P − S last 8.

A synthesizer control path programs it with a band bit and a 5-bit channel word. With the band bit high, P is 32. With the band bit low, P is 34. The legal channel words are 1 to 31. The channel word and band bit are captured only when a cycle ends, so a new setting always starts on a clean cycle. The output is a strobe that is high for one input clock once per M input clocks.

Top module: `fdiv_ctrl`

## Requirements
- R1: While `rst_n` is low, `div_out` is low. After reset the block runs one cycle with band high and channel 1, whatever its inputs are. Counting the first rising clock edge with `rst_n` high as edge 1, `div_out` is low after edge 513 and high after edge 514.
- R2: With `band_hi` = 1 and `chan_sel` = S (1 to 31), the distance between consecutive `div_out` strobes is 2·(8·32 + S) input clocks.
- R3: With `band_hi` = 0 and `chan_sel` = S (1 to 31), the distance between consecutive strobes is 2·(8·34 + S) input clocks.
- R4: The end points of the wanted range are reached: band high with S = 1 gives 514, and band low with S = 22 gives 588.
- R5: `band_hi` and `chan_sel` are captured only on the clock edge that ends a cycle. A change made during a cycle leaves the length of that cycle unchanged and applies from the next cycle on.
- R6: `div_out` is high for exactly one input clock per cycle.
- R7: In each cycle the 8/9 prescaler divides by 9 until the second prescaler's count reaches S, and by 8 after that. The modulus flop is set when the count reaches S and cleared at the wrap, and it is never told to set and clear on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| band_hi | input | 1 | Band select: 1 gives P = 32, 0 gives P = 34 |
| chan_sel | input | 5 | Channel word S, legal range 1 to 31 |
| div_out | output | 1 | One-clock strobe, once per M input clocks |

## Verification
The strobe is registered one edge after the wrap decode. Because of that, the gap between two strobes equals the cycle length exactly, and the first strobe after reset falls on edge 514. The bench samples one time unit after each rising edge and counts edges from one strobe to the next, so every interval it measures is exact and not off by one.

A setting written just after a strobe is not captured until the next wrap. The bench therefore expects the old ratio for the interval that follows and the new ratio for the interval after that. The mid-cycle change test and the reset test use the same reasoning.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned PRE_N     = 8;   // lower modulus of the 8/9 prescaler
  localparam int unsigned P_HI      = 32;  // second-prescaler length, band high
  localparam int unsigned P_LO      = 34;  // second-prescaler length, band low
  localparam int unsigned FRONT_DIV = 2;   // front halving stage
  localparam int unsigned CHW       = 5;   // channel word width
  localparam int unsigned CNTW      = $clog2(P_LO);
  localparam int unsigned PREW      = $clog2(PRE_N + 1);
  localparam int unsigned RST_CHAN  = 1;   // channel used for the first cycle after reset
  localparam bit          RST_BAND  = 1'b1;
endpackage

// File: rtl/fdiv_front.sv
module fdiv_front #(
  parameter int unsigned DIV = fdiv_pkg::FRONT_DIV
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The two-cycle spacing of the front tick is what makes every ratio even
  AST_FRONT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/fdiv_pre89.sv
module fdiv_pre89 #(
  parameter int unsigned N = fdiv_pkg::PRE_N,
  parameter int unsigned W = fdiv_pkg::PREW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic mod_hi_i,
  output logic tick_o
);
  localparam logic [W-1:0] LIM_LONG  = W'(N);
  localparam logic [W-1:0] LIM_SHORT = W'(N - 1);

  logic [W-1:0] cnt_q, cnt_d, lim;

  assign lim    = mod_hi_i ? LIM_SHORT : LIM_LONG;
  assign tick_o = en_i && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_LONG); // R7
endmodule

// File: rtl/fdiv_pre2.sv
module fdiv_pre2 #(
  parameter int unsigned CNTW = fdiv_pkg::CNTW,
  parameter int unsigned CHW  = fdiv_pkg::CHW,
  parameter int unsigned PH   = fdiv_pkg::P_HI,
  parameter int unsigned PL   = fdiv_pkg::P_LO
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            band_hi_i,
  input  logic [CHW-1:0]  chan_i,
  output logic            set_o,
  output logic            clr_o,
  output logic            wrap_o,
  output logic [CNTW-1:0] cnt_o,
  output logic [CHW-1:0]  chan_o
);
  localparam logic [CNTW-1:0] LAST_HI  = CNTW'(PH - 1);
  localparam logic [CNTW-1:0] LAST_LO  = CNTW'(PL - 1);
  localparam logic [CHW-1:0]  RST_CH   = CHW'(fdiv_pkg::RST_CHAN);
  localparam logic            RST_BD   = fdiv_pkg::RST_BAND;
  localparam logic            RST_HIT  = (fdiv_pkg::RST_CHAN == 1);
  localparam logic            RST_TERM = 1'b0;

  logic            band_q, band_d;
  logic [CHW-1:0]  chan_q, chan_d;
  logic [CNTW-1:0] cnt_q, cnt_d, last_d, tgt_d, last_q;
  logic            term_q, term_d, hit_q, hit_d;

  // The qualifier flops hold the decodes one count ahead, so that J and K
  // are ready on the same tick that advances the count.
  assign wrap_o = en_i && term_q;
  assign clr_o  = wrap_o;
  assign set_o  = en_i && hit_q;
  assign cnt_o  = cnt_q;
  assign chan_o = chan_q;
  assign last_q = band_q ? LAST_HI : LAST_LO;

  always_comb begin
    band_d = wrap_o ? band_hi_i : band_q;
    chan_d = wrap_o ? chan_i    : chan_q;
    cnt_d  = cnt_q;
    if (en_i) cnt_d = term_q ? '0 : cnt_q + 1'b1;
    last_d = band_d ? LAST_HI : LAST_LO;
    tgt_d  = CNTW'(chan_d) - 1'b1;
    term_d = term_q;
    hit_d  = hit_q;
    if (en_i) begin
      term_d = &(~(cnt_d ^ last_d));
      hit_d  = &(~(cnt_d ^ tgt_d));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= RST_BD;
      chan_q <= RST_CH;
      cnt_q  <= '0;
      term_q <= RST_TERM;
      hit_q  <= RST_HIT;
    end else begin
      band_q <= band_d;
      chan_q <= chan_d;
      cnt_q  <= cnt_d;
      term_q <= term_d;
      hit_q  <= hit_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_q); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> $stable({band_q, chan_q})); // R5
endmodule

// File: rtl/fdiv_jk.sv
module fdiv_jk (
  input  logic clk,
  input  logic rst_n,
  input  logic j_i,
  input  logic k_i,
  output logic q_o
);
  logic q_q, q_d;

  assign q_o = q_q;

  always_comb begin
    unique case ({j_i, k_i})
      2'b10:   q_d = 1'b1;
      2'b01:   q_d = 1'b0;
      2'b11:   q_d = ~q_q;
      default: q_d = q_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  AST_JK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(j_i && k_i)); // R7
endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl #(
  parameter int unsigned CHW  = fdiv_pkg::CHW,
  parameter int unsigned CNTW = fdiv_pkg::CNTW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           band_hi,
  input  logic [CHW-1:0] chan_sel,
  output logic           div_out
);
  logic            half_tick, pre_tick, mod_hi;
  logic            j_set, k_clr, wrap;
  logic [CNTW-1:0] cnt;
  logic [CHW-1:0]  chan_lat;
  logic            out_q, out_d;

  fdiv_front u_front (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (half_tick)
  );

  fdiv_pre89 u_pre89 (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (half_tick),
    .mod_hi_i (mod_hi),
    .tick_o   (pre_tick)
  );

  fdiv_pre2 #(.CNTW(CNTW), .CHW(CHW)) u_pre2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (pre_tick),
    .band_hi_i (band_hi),
    .chan_i    (chan_sel),
    .set_o     (j_set),
    .clr_o     (k_clr),
    .wrap_o    (wrap),
    .cnt_o     (cnt),
    .chan_o    (chan_lat)
  );

  fdiv_jk u_jk (
    .clk   (clk),
    .rst_n (rst_n),
    .j_i   (j_set),
    .k_i   (k_clr),
    .q_o   (mod_hi)
  );

  assign out_d   = wrap;
  assign div_out = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |=> !out_q); // R6
  AST_MOD_SET_AT_S: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> (cnt == CNTW'(chan_lat))); // R7
  AST_MOD_CLR_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_hi) |-> (cnt == '0)); // R7
endmodule

// File: tb/fdiv_ctrl_bench.sv
`timescale 1ns/1ps
module fdiv_ctrl_bench;
  localparam int WD_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       band_hi = 1'b1;
  logic [4:0] chan_sel = 5'd1;
  logic       div_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cur_m = 0;

  fdiv_ctrl u_fdiv_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .band_hi  (band_hi),
    .chan_sel (chan_sel),
    .div_out  (div_out)
  );

  always #4 clk = ~clk;

  function automatic int ratio(input bit b, input int s);
    return 2 * (8 * (b ? 32 : 34) + s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called one time unit after a strobe edge; returns edges to the next strobe.
  task automatic measure(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!div_out && n < 4000);
  endtask

  task automatic sync_pulse();
    int n;
    measure(n);
  endtask

  // R1: reset state and first cycle on defaults
  task automatic t_reset(input bit b, input int s);
    int n;
    rst_n = 1'b0; band_hi = b; chan_sel = 5'(s);
    repeat (5) @(posedge clk);
    #1;
    chk(div_out == 1'b0, "R1 output low in reset", int'(div_out), 0);
    rst_n = 1'b1;
    repeat (513) @(posedge clk);
    #1;
    chk(div_out == 1'b0, "R1 no strobe before edge 514", int'(div_out), 0);
    @(posedge clk); #1;
    chk(div_out == 1'b1, "R1 first strobe on edge 514", int'(div_out), 1);
    measure(n);
    chk(n == ratio(b, s), "R1 inputs captured at first wrap", n, ratio(b, s));
    cur_m = ratio(b, s);
  endtask

  // R6: strobe width
  task automatic t_width();
    sync_pulse();
    @(posedge clk); #1;
    chk(div_out == 1'b0, "R6 strobe one clock wide", int'(div_out), 0);
    sync_pulse();
  endtask

  // R2 / R3 / R5: sweep one band over every legal channel
  task automatic t_sweep(input bit b);
    int n;
    for (int s = 1; s <= 31; s++) begin
      band_hi = b; chan_sel = 5'(s);
      measure(n);
      chk(n == cur_m, "R5 running cycle keeps old setting", n, cur_m);
      measure(n);
      chk(n == ratio(b, s), b ? "R2 band high ratio" : "R3 band low ratio", n, ratio(b, s));
      cur_m = ratio(b, s);
    end
  endtask

  // R4: end points of the band plan
  task automatic t_ends();
    int n;
    band_hi = 1'b1; chan_sel = 5'd1;
    sync_pulse();
    measure(n);
    chk(n == 514, "R4 lowest ratio", n, 514);
    band_hi = 1'b0; chan_sel = 5'd22;
    sync_pulse();
    measure(n);
    chk(n == 588, "R4 highest wanted ratio", n, 588);
    cur_m = 588;
  endtask

  // R5: change made mid-cycle
  task automatic t_midchange();
    int n;
    repeat (100) @(posedge clk);
    #1;
    band_hi = 1'b1; chan_sel = 5'd9;
    measure(n);
    chk(n == cur_m - 100, "R5 mid-cycle change ignored", n, cur_m - 100);
    measure(n);
    chk(n == ratio(1'b1, 9), "R5 change applied next cycle", n, ratio(1'b1, 9));
    cur_m = ratio(1'b1, 9);
  endtask

  initial begin
    t_reset(1'b0, 5);
    t_width();
    t_sweep(1'b1);
    t_sweep(1'b0);
    t_ends();
    t_midchange();
    repeat (37) @(posedge clk);
    t_reset(1'b1, 31);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule